// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block takes an SDRAM device into and out of its low-power self-refresh state on behalf of a simple memory controller. Software starts the process by writing a one to a single command bit. The block then issues the self-refresh entry command and drives the clock-enable line low. It keeps that line low while the device refreshes itself from its own internal timing.

An access request from the bus side wakes the device. The block first honours a programmable minimum residency time. It then raises clock enable and issues NOP commands for a programmable recovery delay. At the end of that delay it clears the command bit and hands the bus back to the normal command path by raising ready. It never returns to self-refresh on its own: software must write the bit again.

Both timing counts are 4-bit values written in the same register write as the command bit. They are captured at the moment of entry.

Top module: `sref_ctrl`

## Requirements
- R1: After reset, cke is 1, csN is 1, ready is 1 and status is 0.
- R2: A write with cfgCmd=1 while idle and with the bit clear makes status 1 on the next cycle. One cycle after that, the entry command is issued for exactly one cycle: csN=0, rasN=0, casN=0, weN=1, cke=0, ready=0.
- R3: While in self-refresh, cke stays 0, ready stays 0 and csN stays 1. This holds for as long as no access request arrives, with no upper limit.
- R4: Let N be the residency field captured at entry, with 0 read as 1. cke stays low for at least N+1 consecutive cycles, counting the entry cycle. A request that arrives earlier is held off, so a request present from the entry cycle gives exactly N+1 low cycles.
- R5: On exit, cke returns to 1 and the block issues NOP commands (csN=0, rasN=1, casN=1, weN=1) with ready=0. This lasts for exactly D cycles, where D is the recovery field captured at entry, with 0 read as 1.
- R6: status becomes 0 in the same cycle that ready returns to 1. Afterwards the block stays idle, with cke=1 and csN=1, until the command bit is written again.
- R7: A write to the command bit from the entry cycle until ready returns to 1 is ignored. This includes a write in the final recovery cycle.
- R8: Timing fields written while a self-refresh sequence is running do not change that sequence. Only the counts captured at entry govern it.
- R9: While idle, ready is 1 regardless of accessReq, and no command is driven (csN=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgCmd | input | 1 | Value written to the self-refresh command bit |
| cfgMinRes | input | 4 | Minimum residency count |
| cfgExitDly | input | 4 | Exit recovery count |
| accessReq | input | 1 | Access request from the bus side |
| ready | output | 1 | Access may proceed on the normal command path |
| status | output | 1 | Read-back of the command bit |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | SDRAM row strobe, active low |
| casN | output | 1 | SDRAM column strobe, active low |
| weN | output | 1 | SDRAM write enable, active low |
| cke | output | 1 | SDRAM clock enable |

## Verification
Two events can land in the same cycle: a software write that sets the command bit, and the recovery counter finishing, which clears that same bit. The bench provokes this by writing cfgCmd=1 during the last NOP cycle of an exit. It then judges that status reads 0 when ready returns and that cke stays high in the cycles that follow, so the clear has won and no new entry was started. A second overlap, where a request arrives while the residency counter is still running, is judged by counting the cke-low cycles.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ENTER, ST_SELF, ST_EXIT} srefState_t;

  typedef struct packed {
    logic acceptCmd;
    logic latchCfg;
    logic loadRes;
    logic loadXsr;
    logic decCnt;
    logic clearCmd;
  } srefStrb_t;
endpackage

// File: rtl/sref_datapath.sv
module sref_datapath
  import sref_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  srefStrb_t          strb,
  input  logic               cfgWe,
  input  logic               cfgCmd,
  input  logic [FIELD_W-1:0] cfgMinRes,
  input  logic [FIELD_W-1:0] cfgExitDly,
  output logic               cmdBit,
  output logic               cntLast
);
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  logic [FIELD_W-1:0] shRes, shXsr;
  logic [FIELD_W-1:0] actRes, actXsr;
  logic [FIELD_W-1:0] cnt;

  function automatic logic [FIELD_W-1:0] atLeastOne(input logic [FIELD_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shRes  <= '0;
      shXsr  <= '0;
      actRes <= '0;
      actXsr <= '0;
    end else begin
      if (cfgWe) begin
        shRes <= cfgMinRes;
        shXsr <= cfgExitDly;
      end
      if (strb.latchCfg) begin
        actRes <= shRes;
        actXsr <= shXsr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBit <= 1'b0;
    end else if (strb.clearCmd) begin
      cmdBit <= 1'b0;
    end else if (cfgWe && strb.acceptCmd) begin
      cmdBit <= cfgCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= ONE;
    end else if (strb.loadRes) begin
      cnt <= atLeastOne(actRes);
    end else if (strb.loadXsr) begin
      cnt <= atLeastOne(actXsr);
    end else if (strb.decCnt && cnt > ONE) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntLast = (cnt <= ONE);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCmd |=> !cmdBit);
  assert_recovery_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadXsr |=> (cnt != '0));
endmodule

// File: rtl/sref_control.sv
module sref_control
  import sref_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdBit,
  input  logic      cntLast,
  input  logic      accessReq,
  output srefStrb_t strb,
  output logic      ready,
  output logic      csN,
  output logic      rasN,
  output logic      casN,
  output logic      weN,
  output logic      cke
);
  srefState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        strb.acceptCmd = !cmdBit;
        if (cmdBit) begin
          strb.latchCfg = 1'b1;
          stateNxt      = ST_ENTER;
        end
      end
      ST_ENTER: begin
        strb.loadRes = 1'b1;
        stateNxt     = ST_SELF;
      end
      ST_SELF: begin
        if (cntLast && accessReq) begin
          strb.loadXsr = 1'b1;
          stateNxt     = ST_EXIT;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      ST_EXIT: begin
        if (cntLast) begin
          strb.clearCmd = 1'b1;
          stateNxt      = ST_IDLE;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ready = 1'b0;
    csN   = 1'b1;
    rasN  = 1'b1;
    casN  = 1'b1;
    weN   = 1'b1;
    cke   = 1'b1;
    unique case (state)
      ST_IDLE:  ready = 1'b1;
      ST_ENTER: begin
        csN  = 1'b0;
        rasN = 1'b0;
        casN = 1'b0;
        cke  = 1'b0;
      end
      ST_SELF:  cke = 1'b0;
      ST_EXIT:  csN = 1'b0;
      default:  ready = 1'b1;
    endcase
  end

  assert_entry_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTER) |=> (state == ST_SELF));
  assert_min_residency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELF && !cntLast) |=> (state == ST_SELF));
  assert_recovery_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXIT && !cntLast) |=> (state == ST_EXIT));
  assert_bit_held_in_seq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> cmdBit);
endmodule

// File: rtl/sref_ctrl.sv
module sref_ctrl
  import sref_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgCmd,
  input  logic [FIELD_W-1:0] cfgMinRes,
  input  logic [FIELD_W-1:0] cfgExitDly,
  input  logic               accessReq,
  output logic               ready,
  output logic               status,
  output logic               csN,
  output logic               rasN,
  output logic               casN,
  output logic               weN,
  output logic               cke
);
  srefStrb_t strb;
  logic      cmdBit;
  logic      cntLast;

  sref_datapath #(.FIELD_W(FIELD_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgWe      (cfgWe),
    .cfgCmd     (cfgCmd),
    .cfgMinRes  (cfgMinRes),
    .cfgExitDly (cfgExitDly),
    .cmdBit     (cmdBit),
    .cntLast    (cntLast)
  );

  sref_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdBit    (cmdBit),
    .cntLast   (cntLast),
    .accessReq (accessReq),
    .strb      (strb),
    .ready     (ready),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .cke       (cke)
  );

  assign status = cmdBit;
endmodule

// File: tb/tb_sref_ctrl.sv
module tb_sref_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic cfgCmd = 1'b0;
  logic [3:0] cfgMinRes = '0;
  logic [3:0] cfgExitDly = '0;
  logic accessReq = 1'b0;
  logic ready, status, csN, rasN, casN, weN, cke;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sref_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCmd(cfgCmd),
    .cfgMinRes(cfgMinRes), .cfgExitDly(cfgExitDly), .accessReq(accessReq),
    .ready(ready), .status(status), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .cke(cke)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input bit cmd, input int res, input int xsr);
    cfgWe = 1'b1; cfgCmd = cmd; cfgMinRes = 4'(res); cfgExitDly = 4'(xsr);
    step();
    cfgWe = 1'b0;
  endtask

  // Sets the bit, checks status, then lands on the entry cycle and checks it.
  task automatic enterSeq(input int res, input int xsr);
    doWrite(1'b1, res, xsr);
    chk(status == 1'b1 && cke == 1'b1, "R2 status set", status, 1);
    step();
    chk({csN, rasN, casN, weN, cke, ready} == 6'b000100, "R2 entry command",
        {csN, rasN, casN, weN, cke, ready}, 6'b000100);
  endtask

  // Called on the first exit cycle; counts NOP cycles until ready returns.
  task automatic measureExit(input int expD);
    int nExit = 0;
    bit nopOk = 1'b1;
    for (int i = 0; i < 40 && ready == 1'b0; i++) begin
      if ({csN, rasN, casN, weN, cke} != 5'b01111) nopOk = 1'b0;
      nExit++;
      step();
    end
    chk(nopOk, "R5 NOP during recovery", nopOk, 1);
    chk(nExit == expD, "R5 recovery length", nExit, expD);
    chk(status == 1'b0 && ready == 1'b1, "R6 bit clears with ready", status, 0);
  endtask

  // Called on the entry cycle with accessReq already high.
  task automatic measureFull(input int expLow, input int expD);
    int nLow = 0;
    for (int i = 0; i < 40 && cke == 1'b0; i++) begin
      nLow++;
      step();
    end
    chk(nLow == expLow, "R4 residency length", nLow, expLow);
    measureExit(expD);
    accessReq = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    chk({cke, csN, ready, status} == 4'b1110, "R1 reset state",
        {cke, csN, ready, status}, 4'b1110);
  endtask

  task automatic tBasic();
    enterSeq(3, 2);
    accessReq = 1'b1;
    measureFull(4, 2);
  endtask

  task automatic tZeroFields();
    enterSeq(0, 0);
    accessReq = 1'b1;
    measureFull(2, 1);
  endtask

  task automatic tLongStayAndIgnore();
    bit holdOk = 1'b1;
    enterSeq(2, 3);
    for (int i = 0; i < 20; i++) begin
      step();
      if (!(cke == 1'b0 && ready == 1'b0 && csN == 1'b1)) holdOk = 1'b0;
    end
    chk(holdOk, "R3 held in self-refresh", holdOk, 1);
    doWrite(1'b0, 5, 4);
    chk(status == 1'b1 && cke == 1'b0, "R7 clear write ignored", status, 1);
    accessReq = 1'b1;
    step();
    chk(cke == 1'b1 && ready == 1'b0, "R5 exit begins", cke, 1);
    measureExit(3); // R8: the count captured at entry (3), not the 4 written later
    accessReq = 1'b0;
  endtask

  task automatic tNoReentry();
    bit idleOk = 1'b1;
    accessReq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (!(cke == 1'b1 && csN == 1'b1 && status == 1'b0 && ready == 1'b1)) idleOk = 1'b0;
    end
    chk(idleOk, "R6 R9 stays idle, ready with request", idleOk, 1);
    accessReq = 1'b0;
  endtask

  task automatic tWriteAtExitEnd();
    bit idleOk = 1'b1;
    enterSeq(1, 2);
    accessReq = 1'b1;
    for (int i = 0; i < 40 && cke == 1'b0; i++) step();
    step();
    chk(ready == 1'b0 && cke == 1'b1, "R5 last recovery cycle", ready, 0);
    doWrite(1'b1, 1, 2);
    chk(status == 1'b0 && ready == 1'b1, "R7 write in last cycle ignored", status, 0);
    accessReq = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (!(cke == 1'b1 && status == 1'b0)) idleOk = 1'b0;
    end
    chk(idleOk, "R6 no re-entry after overlap", idleOk, 1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
        $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
        $finish;
      end
    end
  end

  initial begin
    #1;
    tReset();
    tBasic();
    tNoReentry();
    tZeroFields();
    tLongStayAndIgnore();
    tWriteAtExitEnd();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule